// File: doc/BRIEF.md
# Serial Flash Bus Arbiter with Automatic Operation Suspend

This block shares one serial flash bus between two requesters. A cache-fill port issues short reads. A command port issues flash operations of any kind, including long ones such as sector or chip erase, page program and status-register write. Short command operations run to completion before the cache port is served. When a long operation holds the bus and a cache read arrives, the arbiter interrupts that operation. It sends the flash a suspend opcode toward a simple bus engine, waits out a configurable suspend latency, and confirms the suspended state from the device's status word. It then hands the bus to the cache port.

After each cache transfer during a suspension, the cache port keeps the bus for a lock window. Any further cache request in that window is served at once, and the window starts again when that transfer ends. When a window expires with no request, the arbiter sends a resume opcode and returns the bus to the command port. It then holds off further suspends for a preparation interval, so that the interrupted operation makes real progress. A cache request that arrives during that interval waits, and the suspend is issued as soon as the interval ends. All three intervals are counted in clock cycles and are captured from configuration inputs while reset is high.

Top module: `flash_susp_arb`

## Requirements
- R1: While reset is high, and at the first cycle after it, no grant is given, `ctl_vld` is 0, `bus_lock` is 0 and `op_suspended` is 0.
- R2: A command operation that is not in the long set runs to completion with no suspend opcode. A cache request waiting on it is granted exactly 2 cycles after the cycle in which `cmd_done` is high. A cache transfer that is not inside a suspension has `bus_lock` low.
- R3: Command opcodes 0x20, 0x52, 0xD8, 0xC7, 0x60, 0x02 and 0x01 form the long set. A pending cache request while such an operation owns the bus, outside the preparation interval, makes `ctl_vld` high for exactly one cycle with `ctl_op` = 0x75. This happens on the cycle after the command grant, or the cycle after the request is seen.
- R4: After the suspend opcode cycle S, the cache grant comes only once the tSUS count has elapsed and `flash_sts[15]` (the device's suspend flag) has been seen high. When the flag is already high, the grant lands at S+tSUS+2. When the flag rises later, the grant lands one cycle after the cycle in which it is first high.
- R5: Only one level of suspend exists. During a suspension `bus_lock` is high while the cache port transfers and while the lock window runs. A cache request during the window is granted one cycle after it is raised, with no further suspend opcode, and this includes the window's last cycle.
- R6: If a window opened by `cache_done` in cycle D passes with no cache request, the resume opcode (`ctl_vld` with `ctl_op` = 0x7A) appears in cycle D+L+2. `bus_lock` is high at D+L+1 and low from D+L+2 on. `op_suspended` returns to 0 after the resume.
- R7: After a resume in cycle R, no suspend opcode is issued before R+P+2. A cache request held pending from R onward causes the suspend opcode exactly at R+P+2.
- R8: When both ports request while the bus is free, the winner alternates with the last port granted from the free state. The cache port wins the first such contest after reset.
- R9: The tSUS, lock and preparation counts are taken from `cfg_tsus_cyc`, `cfg_lock_cyc` and `cfg_prep_cyc` while reset is high. Changing those inputs afterwards has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration captured while high |
| cfg_tsus_cyc | input | CW | Suspend latency in cycles |
| cfg_lock_cyc | input | CW | Lock window length in cycles |
| cfg_prep_cyc | input | CW | Post-resume preparation interval in cycles |
| cache_req | input | 1 | Cache port request, held until granted |
| cache_done | input | 1 | One-cycle pulse: cache transfer finished |
| cache_gnt | output | 1 | One-cycle pulse: cache port owns the bus |
| cmd_req | input | 1 | Command port request, held until granted |
| cmd_op | input | 8 | Opcode of the requested command operation |
| cmd_done | input | 1 | One-cycle pulse: command operation finished |
| cmd_gnt | output | 1 | One-cycle pulse: command port owns the bus |
| flash_sts | input | 16 | Device status word; bit 15 is the suspended flag |
| ctl_vld | output | 1 | One-cycle pulse: send `ctl_op` to the flash |
| ctl_op | output | 8 | Suspend (0x75) or resume (0x7A) opcode |
| bus_lock | output | 1 | Cache port holds the bus inside a suspension |
| op_suspended | output | 1 | A long operation is currently suspended |

## Verification
The bench goes after the exact cycles at which the three windows end. A counter that is one cycle off would move a grant or opcode off its computed cycle. It holds the status flag low past the tSUS count, where a design that ignored the flag would grant too early. It raises a cache request on the lock window's final cycle, where a design that let expiry win would emit a resume and a needless second suspend. It also checks that a read blocks the cache port without a suspend, that contention alternates between the ports, and that configuration changes after reset do not shift any timing.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    localparam logic [7:0] OP_SUSPEND = 8'h75;
    localparam logic [7:0] OP_RESUME  = 8'h7A;
    localparam int         STS_SUS_BIT = 15;

    // timer slots
    localparam int TMR_TSUS = 0;
    localparam int TMR_LOCK = 1;
    localparam int TMR_PREP = 2;
    localparam int TMR_NUM  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CACHE,
        ST_CMD,
        ST_SUSP,
        ST_SWAIT,
        ST_LOCK,
        ST_RESUME
    } arb_st_e;

    typedef enum logic {
        WIN_CACHE = 1'b0,
        WIN_CMD   = 1'b1
    } win_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] op;
    } ctl_t;

    // operations that take long enough to be worth suspending
    function automatic logic is_long_op(input logic [7:0] op);
        case (op)
            8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'h02, 8'h01: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fsa_timer.sv
module fsa_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fsa_rr_pick.sv
module fsa_rr_pick
    import fsa_pkg::*;
(
    input  logic cache_req,
    input  logic cmd_req,
    input  win_e last_win,
    output logic pick_cache,
    output logic pick_cmd
);
    always_comb begin
        pick_cache = 1'b0;
        pick_cmd   = 1'b0;
        if (cache_req && cmd_req) begin
            if (last_win == WIN_CACHE) pick_cmd   = 1'b1;
            else                       pick_cache = 1'b1;
        end else begin
            pick_cache = cache_req;
            pick_cmd   = cmd_req;
        end
    end
endmodule

// File: rtl/fsa_ctrl.sv
module fsa_ctrl
    import fsa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cache_req,
    input  logic               cache_done,
    input  logic               cmd_req,
    input  logic [7:0]         cmd_op,
    input  logic               cmd_done,
    input  logic               sus_flag,
    input  logic [TMR_NUM-1:0] tmr_zero,
    output logic [TMR_NUM-1:0] tmr_load,
    output logic               cache_gnt,
    output logic               cmd_gnt,
    output ctl_t               ctl,
    output logic               bus_lock,
    output logic               op_suspended
);
    arb_st_e state_q, state_d;
    win_e    last_q;
    logic    long_q, susp_q;
    logic    cgnt_q, mgnt_q;
    logic    give_cache, give_cmd;
    logic    pick_cache, pick_cmd;

    fsa_rr_pick u_pick (
        .cache_req (cache_req),
        .cmd_req   (cmd_req),
        .last_win  (last_q),
        .pick_cache(pick_cache),
        .pick_cmd  (pick_cmd)
    );

    always_comb begin
        state_d    = state_q;
        tmr_load   = '0;
        give_cache = 1'b0;
        give_cmd   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (pick_cache) begin
                    state_d    = ST_CACHE;
                    give_cache = 1'b1;
                end else if (pick_cmd) begin
                    state_d  = ST_CMD;
                    give_cmd = 1'b1;
                end
            end
            ST_CACHE: begin
                if (cache_done) begin
                    if (susp_q) begin
                        state_d            = ST_LOCK;
                        tmr_load[TMR_LOCK] = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CMD: begin
                if (cmd_done)
                    state_d = ST_IDLE;
                else if (long_q && cache_req && tmr_zero[TMR_PREP])
                    state_d = ST_SUSP;
            end
            ST_SUSP: begin
                state_d            = ST_SWAIT;
                tmr_load[TMR_TSUS] = 1'b1;
            end
            ST_SWAIT: begin
                if (tmr_zero[TMR_TSUS] && sus_flag) begin
                    state_d    = ST_CACHE;
                    give_cache = 1'b1;
                end
            end
            ST_LOCK: begin
                if (cache_req) begin
                    state_d    = ST_CACHE;
                    give_cache = 1'b1;
                end else if (tmr_zero[TMR_LOCK]) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                state_d            = ST_CMD;
                tmr_load[TMR_PREP] = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            last_q  <= WIN_CMD;
            long_q  <= 1'b0;
            susp_q  <= 1'b0;
            cgnt_q  <= 1'b0;
            mgnt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cgnt_q  <= give_cache;
            mgnt_q  <= give_cmd;
            if (give_cmd) begin
                long_q <= is_long_op(cmd_op);
                last_q <= WIN_CMD;
            end
            if (give_cache && state_q == ST_IDLE)
                last_q <= WIN_CACHE;
            if (state_q == ST_SUSP)
                susp_q <= 1'b1;
            else if (state_q == ST_RESUME)
                susp_q <= 1'b0;
        end
    end

    always_comb begin
        ctl.vld = (state_q == ST_SUSP) || (state_q == ST_RESUME);
        ctl.op  = (state_q == ST_RESUME) ? OP_RESUME : OP_SUSPEND;
    end

    assign cache_gnt    = cgnt_q;
    assign cmd_gnt      = mgnt_q;
    assign bus_lock     = (state_q == ST_LOCK) || (state_q == ST_CACHE && susp_q);
    assign op_suspended = susp_q;
endmodule

// File: rtl/flash_susp_arb.sv
module flash_susp_arb
    import fsa_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_tsus_cyc,
    input  logic [CW-1:0] cfg_lock_cyc,
    input  logic [CW-1:0] cfg_prep_cyc,
    input  logic          cache_req,
    input  logic          cache_done,
    output logic          cache_gnt,
    input  logic          cmd_req,
    input  logic [7:0]    cmd_op,
    input  logic          cmd_done,
    output logic          cmd_gnt,
    input  logic [15:0]   flash_sts,
    output logic          ctl_vld,
    output logic [7:0]    ctl_op,
    output logic          bus_lock,
    output logic          op_suspended
);
    logic [CW-1:0]      cfg_q [TMR_NUM];
    logic [CW-1:0]      cfg_in [TMR_NUM];
    logic [TMR_NUM-1:0] tmr_load, tmr_zero;
    ctl_t               ctl;

    assign cfg_in[TMR_TSUS] = cfg_tsus_cyc;
    assign cfg_in[TMR_LOCK] = cfg_lock_cyc;
    assign cfg_in[TMR_PREP] = cfg_prep_cyc;

    for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst) cfg_q[g] <= cfg_in[g];
        end

        fsa_timer #(.CW(CW)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .load    (tmr_load[g]),
            .load_val(cfg_q[g]),
            .zero    (tmr_zero[g])
        );
    end

    fsa_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cache_req   (cache_req),
        .cache_done  (cache_done),
        .cmd_req     (cmd_req),
        .cmd_op      (cmd_op),
        .cmd_done    (cmd_done),
        .sus_flag    (flash_sts[STS_SUS_BIT]),
        .tmr_zero    (tmr_zero),
        .tmr_load    (tmr_load),
        .cache_gnt   (cache_gnt),
        .cmd_gnt     (cmd_gnt),
        .ctl         (ctl),
        .bus_lock    (bus_lock),
        .op_suspended(op_suspended)
    );

    assign ctl_vld = ctl.vld;
    assign ctl_op  = ctl.op;
endmodule

// File: rtl/fsa_chk.sv
module fsa_chk
    import fsa_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cfg_tsus_cyc,
    input logic [CW-1:0] cfg_prep_cyc,
    input logic          cache_gnt,
    input logic          cmd_gnt,
    input logic [15:0]   flash_sts,
    input logic          ctl_vld,
    input logic [7:0]    ctl_op,
    input logic          bus_lock,
    input logic          op_suspended
);
    localparam int SW = CW + 2;

    logic [CW-1:0] tsus_q, prep_q;
    logic [SW-1:0] since_sus, since_res;
    logic          seen_res;
    logic          sus_op, res_op;

    assign sus_op = ctl_vld && ctl_op == OP_SUSPEND;
    assign res_op = ctl_vld && ctl_op == OP_RESUME;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsus_q    <= cfg_tsus_cyc;
            prep_q    <= cfg_prep_cyc;
            since_sus <= '0;
            since_res <= '0;
            seen_res  <= 1'b0;
        end else begin
            if (sus_op) since_sus <= SW'(1);
            else if (since_sus != '1) since_sus <= since_sus + 1'b1;
            if (res_op) begin
                since_res <= SW'(1);
                seen_res  <= 1'b1;
            end else if (since_res != '1) begin
                since_res <= since_res + 1'b1;
            end
        end
    end

    // R1
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cache_gnt, cmd_gnt, ctl_vld}));

    // R3
    legal_op_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_vld |-> (ctl_op == OP_SUSPEND || ctl_op == OP_RESUME));

    // R4
    tsus_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_gnt && op_suspended) |->
            (since_sus > SW'(tsus_q) + SW'(1) && $past(flash_sts[STS_SUS_BIT])));

    // R5
    single_level_chk: assert property (@(posedge clk) disable iff (rst)
        sus_op |-> !op_suspended);

    // R6
    resume_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        res_op |-> ($past(bus_lock) && !bus_lock && op_suspended));

    // R7
    prep_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (sus_op && seen_res) |-> since_res > SW'(prep_q) + SW'(1));
endmodule

bind flash_susp_arb fsa_chk #(.CW(CW)) u_fsa_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_tsus_cyc(cfg_tsus_cyc),
    .cfg_prep_cyc(cfg_prep_cyc),
    .cache_gnt   (cache_gnt),
    .cmd_gnt     (cmd_gnt),
    .flash_sts   (flash_sts),
    .ctl_vld     (ctl_vld),
    .ctl_op      (ctl_op),
    .bus_lock    (bus_lock),
    .op_suspended(op_suspended)
);

// File: tb/test_flash_susp_arb.sv
module test_flash_susp_arb;
    localparam int CW = 16;
    localparam int T  = 3;
    localparam int L  = 4;
    localparam int P  = 6;
    localparam int K_CACHE = 0;
    localparam int K_CMD   = 1;
    localparam int K_OP    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_tsus_cyc = CW'(T);
    logic [CW-1:0] cfg_lock_cyc = CW'(L);
    logic [CW-1:0] cfg_prep_cyc = CW'(P);
    logic          cache_req = 1'b0, cache_done = 1'b0, cache_gnt;
    logic          cmd_req = 1'b0, cmd_done = 1'b0, cmd_gnt;
    logic [7:0]    cmd_op = 8'h03;
    logic [15:0]   flash_sts = 16'h0000;
    logic          ctl_vld, bus_lock, op_suspended;
    logic [7:0]    ctl_op;

    flash_susp_arb #(.CW(CW)) i_flash_susp_arb (
        .clk(clk), .rst(rst),
        .cfg_tsus_cyc(cfg_tsus_cyc), .cfg_lock_cyc(cfg_lock_cyc), .cfg_prep_cyc(cfg_prep_cyc),
        .cache_req(cache_req), .cache_done(cache_done), .cache_gnt(cache_gnt),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_done(cmd_done), .cmd_gnt(cmd_gnt),
        .flash_sts(flash_sts), .ctl_vld(ctl_vld), .ctl_op(ctl_op),
        .bus_lock(bus_lock), .op_suspended(op_suspended)
    );

    always #2 clk = ~clk;

    typedef struct {
        int         kind;
        logic [7:0] op;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input logic [7:0] op, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.op = op; e.cyc = at; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic take(input int kind, input logic [7:0] op);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, "unexpected event", kind * 1000 + int'(op), -1);
        end else begin
            e = q.pop_front();
            chk(e.kind == kind && e.op == op, {e.tag, " event kind/op"},
                kind * 1000 + int'(op), e.kind * 1000 + int'(e.op));
            chk(e.cyc == cyc, {e.tag, " event cycle"}, cyc, e.cyc);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cache_gnt) take(K_CACHE, 8'h00);
            if (cmd_gnt)   take(K_CMD, 8'h00);
            if (ctl_vld)   take(K_OP, ctl_op);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int d;
        int r;
        int s;
        step(3);
        // R1: reset state
        chk(!cache_gnt && !cmd_gnt && !ctl_vld, "R1 grants/ctl in reset", 1, 0);
        chk(!bus_lock && !op_suspended, "R1 lock/suspended in reset", 1, 0);
        rst = 1'b0;
        // R9: change config after reset; must have no effect
        cfg_tsus_cyc = 16'd20; cfg_lock_cyc = 16'd20; cfg_prep_cyc = 16'd20;
        step(1);
        chk(!cache_gnt && !cmd_gnt && !ctl_vld && !bus_lock, "R1 first cycle", 1, 0);
        step(1);

        // R8: both request, cache wins first
        cache_req = 1'b1; cmd_req = 1'b1; cmd_op = 8'h03;
        push(K_CACHE, 8'h00, cyc + 1, "R8 first contest");
        step(1); cache_req = 1'b0;
        step(2);
        cache_done = 1'b1;
        push(K_CMD, 8'h00, cyc + 2, "R8 cmd after cache");
        step(1); cache_done = 1'b0;
        step(1); cmd_req = 1'b0;

        // R2: short read blocks cache, no suspend
        cache_req = 1'b1;
        step(4);
        chk(!bus_lock && !op_suspended, "R2 no suspend for read", 1, 0);
        cmd_done = 1'b1;
        push(K_CACHE, 8'h00, cyc + 2, "R2 grant after read");
        step(1); cmd_done = 1'b0;
        step(1); cache_req = 1'b0;
        chk(!bus_lock, "R2 no lock outside suspension", 1, 0);
        step(1); cache_done = 1'b1;
        step(1); cache_done = 1'b0;

        // R8 alternation + R3 long op suspended
        cache_req = 1'b1; cmd_req = 1'b1; cmd_op = 8'h20;
        push(K_CMD, 8'h00, cyc + 1, "R8 alternation");
        push(K_OP, 8'h75, cyc + 2, "R3 suspend opcode");
        s = cyc + 2;
        step(1); cmd_req = 1'b0;
        step(1);
        // R4: flag still low past tSUS, no grant yet
        step(T + 4);
        chk(op_suspended, "R4 suspended while waiting flag", 0, 1);
        flash_sts[15] = 1'b1;
        push(K_CACHE, 8'h00, cyc + 1, "R4 grant after flag");
        step(1); cache_req = 1'b0;
        chk(bus_lock, "R5 lock during cache xfer", 0, 1);

        // R5: request inside lock window
        step(1); cache_done = 1'b1; d = cyc;
        step(1); cache_done = 1'b0;
        step(1);
        cache_req = 1'b1;
        push(K_CACHE, 8'h00, cyc + 1, "R5 served in window");
        step(1); cache_req = 1'b0;
        chk(bus_lock, "R5 lock kept", 0, 1);

        // R6: window expires -> resume
        step(1); cache_done = 1'b1; d = cyc;
        push(K_OP, 8'h7A, d + L + 2, "R6 resume timing");
        step(1); cache_done = 1'b0;
        step(L);
        chk(bus_lock, "R6 lock last window cycle", 0, 1);
        step(1); r = cyc;
        chk(!bus_lock, "R6 lock dropped at resume", 1, 0);

        // R7 + R9: pending request waits prep interval
        flash_sts[15] = 1'b0;
        cache_req = 1'b1;
        push(K_OP, 8'h75, r + P + 2, "R7 suspend after prep");
        step(P + 1);
        flash_sts[15] = 1'b1;
        step(1); s = cyc;
        push(K_CACHE, 8'h00, s + T + 2, "R4 grant exact tSUS");
        step(T + 2); cache_req = 1'b0;

        // R5 corner: request on the final window cycle
        step(1); cache_done = 1'b1; d = cyc;
        step(1); cache_done = 1'b0;
        step(L);
        cache_req = 1'b1;
        push(K_CACHE, 8'h00, cyc + 1, "R5 last window cycle");
        step(1); cache_req = 1'b0;
        step(1); cache_done = 1'b1; d = cyc;
        push(K_OP, 8'h7A, d + L + 2, "R6 second resume");
        step(1); cache_done = 1'b0;
        step(L + 1);
        flash_sts[15] = 1'b0;
        step(2);
        cmd_done = 1'b1;
        step(1); cmd_done = 1'b0;
        step(1);
        chk(!op_suspended && !bus_lock, "R6 clear after resume", 1, 0);
        step(3);
        chk(q.size() == 0, "all expected events seen", q.size(), 0);
        finish_run();
    end
endmodule